// File: doc/BRIEF.md
# Shared-Prescaler Timer and Watchdog

This block pairs an 8-bit event timer with a watchdog counter. The two share one programmable prescaler. An 8-bit control word sets up the whole unit. The word cannot be read back. It is loaded in a single cycle from a data bus whenever the load strobe is high. One bit of the word hands the prescaler to the timer or to the watchdog. The same three-bit rate code gives each owner its own division ratio.

The timer counts one of two sources. The first is the internal instruction-cycle tick. The second is the selected edge of an external clock pin, which is first synchronized into the clock domain. When the timer wraps, it raises a sticky overflow flag, which software clears through a dedicated input. The watchdog counts its own base tick, either directly or through the prescaler. Once it runs out, it emits a one-cycle timeout pulse unless it has been cleared in time.

Top module: `tpw_top`

## Requirements
- R1: While rst_ni is low, and after it is released, tmr_o is 0x00, ovf_o is 0 and wdt_timeout_o is 0. The control word resets to 0xFF: external pin source, falling edge, prescaler on the watchdog, rate code 7.
- R2: When cfg_wr_i is high at a rising clock edge, all eight bits of cfg_data_i are loaded into the control word, and the new settings govern counting from the next cycle onward.
- R3: Control bit 5 picks the timer source. With 1 the timer counts edges of ext_clk_i and ignores inst_tick_i. With 0 it counts cycles in which inst_tick_i is high and ignores the pin.
- R4: Control bit 4 picks the pin edge: 0 counts low-to-high and 1 counts high-to-low. The pin passes through two synchronizer flops, so an undivided timer shows the increment after the third rising clock edge that follows the pin change, and not after the second.
- R5: With control bit 3 at 0, the timer advances once per 2^(n+1) source events, where n is the rate code in bits 2:0 (1:2 up to 1:256).
- R6: With control bit 3 at 1, the timer advances by exactly one on every source event.
- R7: With control bit 3 at 1, the watchdog advances once per 2^n wdt_tick_i events (1:1 up to 1:128). With bit 3 at 0, it advances once on every wdt_tick_i event.
- R8: Every control-word load empties the prescaler, so events counted before the load do not carry into the new setting.
- R9: ovf_o sets when the timer steps from 0xFF to 0x00 and stays set until ovf_clr_i is high. If a wrap and a clear fall in the same cycle, the flag ends up set.
- R10: wdt_clr_i zeroes the watchdog counter, and also empties the prescaler when control bit 3 is 1. wdt_timeout_o is a one-cycle pulse in the cycle after the counter steps from all ones to zero. A clear in that same cycle suppresses the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inst_tick_i | input | 1 | Internal instruction-cycle tick, one cycle per event |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| cfg_wr_i | input | 1 | Load strobe for the control word |
| cfg_data_i | input | 8 | Control word data |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| wdt_tick_i | input | 1 | Watchdog base tick, one cycle per event |
| wdt_clr_i | input | 1 | Watchdog restart |
| tmr_o | output | 8 | Timer value |
| ovf_o | output | 1 | Sticky timer overflow flag |
| wdt_timeout_o | output | 1 | Watchdog timeout, one-cycle pulse |

## Verification
Two events can land in the same clock cycle: the timer wrapping from 0xFF to 0x00, and software clearing the overflow flag. The bench steps the timer undivided to 0xFF. In the next cycle it raises inst_tick_i and ovf_clr_i together. The check passes only if ovf_o reads 1 afterwards, because a lost overflow is worse than a redundant one. The watchdog has a similar collision, a restart landing on the wrapping tick. A property covers that case by requiring no timeout pulse in the cycle after any restart.

// File: rtl/tpw_pkg.sv
package tpw_pkg;
  localparam int CFG_W  = 8;
  localparam int RATE_W = 3;

  typedef struct packed {
    logic [1:0]        spare;
    logic              src_ext;
    logic              edge_fall;
    logic              psc_wdt;
    logic [RATE_W-1:0] rate;
  } cfg_t;

  localparam cfg_t CFG_RST = cfg_t'(8'hFF);
endpackage

// File: rtl/tpw_pin_sync.sv
module tpw_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // sr[STAGES-1] is the synchronized level, sr[STAGES] its previous value
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-1:0], pin_i};
  end

  assign rise_o =  sr_q[STAGES-1] & ~sr_q[STAGES];
  assign fall_o = ~sr_q[STAGES-1] &  sr_q[STAGES];
endmodule

// File: rtl/tpw_prescaler.sv
module tpw_prescaler #(
  parameter int CNT_W  = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ev_i,
  input  logic              extra_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int SH_W = $clog2(CNT_W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [SH_W-1:0]  shift;
  logic [CNT_W-1:0] mask;

  // divide by 2^(rate + extra); shift 0 passes events straight through
  assign shift  = SH_W'(rate_i) + SH_W'(extra_i);
  assign mask   = CNT_W'((32'd1 << shift) - 32'd1);
  assign tick_o = ev_i & ~clr_i & ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (ev_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tpw_timer.sv
module tpw_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ovf_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         ovf_q;
  logic         wrap;

  assign wrap = inc_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (inc_i) cnt_q <= cnt_q + 1'b1;
      // a wrap beats a simultaneous clear
      if (wrap)           ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/tpw_wdt.sv
module tpw_wdt #(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic clr_i,
  output logic timeout_o
);
  logic [W-1:0] cnt_q;
  logic         to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      to_q <= inc_i & ~clr_i & (&cnt_q);
      if (clr_i)      cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign timeout_o = to_q;
endmodule

// File: rtl/tpw_top.sv
module tpw_top
  import tpw_pkg::*;
#(
  parameter int TMR_W   = 8,
  parameter int PSC_W   = 8,
  parameter int WDT_W   = 8,
  parameter int SYNC_FF = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inst_tick_i,
  input  logic             ext_clk_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  input  logic             ovf_clr_i,
  input  logic             wdt_tick_i,
  input  logic             wdt_clr_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             ovf_o,
  output logic             wdt_timeout_o
);
  cfg_t cfg_q;
  logic pin_rise, pin_fall, pin_ev, src_ev;
  logic psc_in, psc_clr, psc_tick;
  logic tmr_inc, wdt_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= CFG_RST;
    else if (cfg_wr_i) cfg_q <= cfg_t'(cfg_data_i);
  end

  tpw_pin_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_clk_i),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign pin_ev  = cfg_q.edge_fall ? pin_fall : pin_rise;
  assign src_ev  = cfg_q.src_ext ? pin_ev : inst_tick_i;
  assign psc_in  = cfg_q.psc_wdt ? wdt_tick_i : src_ev;
  assign psc_clr = cfg_wr_i | (cfg_q.psc_wdt & wdt_clr_i);

  tpw_prescaler #(.CNT_W(PSC_W), .RATE_W(RATE_W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (psc_clr),
    .ev_i    (psc_in),
    .extra_i (~cfg_q.psc_wdt),
    .rate_i  (cfg_q.rate),
    .tick_o  (psc_tick)
  );

  assign tmr_inc = cfg_q.psc_wdt ? src_ev : psc_tick;
  assign wdt_inc = cfg_q.psc_wdt ? psc_tick : wdt_tick_i;

  tpw_timer #(.W(TMR_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (tmr_inc),
    .ovf_clr_i (ovf_clr_i),
    .cnt_o     (tmr_o),
    .ovf_o     (ovf_o)
  );

  tpw_wdt #(.W(WDT_W)) u_wdt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (wdt_inc),
    .clr_i     (wdt_clr_i),
    .timeout_o (wdt_timeout_o)
  );
endmodule

// File: rtl/tpw_checker.sv
module tpw_checker #(
  parameter int TMR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ovf_clr_i,
  input logic             wdt_clr_i,
  input logic [TMR_W-1:0] tmr_o,
  input logic             ovf_o,
  input logic             wdt_timeout_o
);
  AST_TO_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_timeout_o |=> !wdt_timeout_o); // R10

  AST_CLR_NO_TO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_i |=> !wdt_timeout_o); // R10

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o); // R9

  AST_OVF_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_o == '0 && $past(tmr_o) == '1) |-> ovf_o); // R9

  AST_TMR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(tmr_o) || tmr_o == TMR_W'($past(tmr_o) + 1'b1)); // R6

  AST_OVF_RISE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> (tmr_o == '0)); // R9
endmodule

bind tpw_top tpw_checker #(.TMR_W(TMR_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ovf_clr_i     (ovf_clr_i),
  .wdt_clr_i     (wdt_clr_i),
  .tmr_o         (tmr_o),
  .ovf_o         (ovf_o),
  .wdt_timeout_o (wdt_timeout_o)
);

// File: tb/tpw_top_tb_top.sv
module tpw_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       inst_tick_i = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       cfg_wr_i = 1'b0;
  logic [7:0] cfg_data_i = 8'h00;
  logic       ovf_clr_i = 1'b0;
  logic       wdt_tick_i = 1'b0;
  logic       wdt_clr_i = 1'b0;
  logic [7:0] tmr_o;
  logic       ovf_o;
  logic       wdt_timeout_o;

  int n_run = 0;
  int n_fail = 0;
  int to_cnt = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  tpw_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .inst_tick_i(inst_tick_i),
    .ext_clk_i(ext_clk_i), .cfg_wr_i(cfg_wr_i), .cfg_data_i(cfg_data_i),
    .ovf_clr_i(ovf_clr_i), .wdt_tick_i(wdt_tick_i), .wdt_clr_i(wdt_clr_i),
    .tmr_o(tmr_o), .ovf_o(ovf_o), .wdt_timeout_o(wdt_timeout_o)
  );

  always @(negedge clk_i) if (wdt_timeout_o) to_cnt++;

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk_i);
  endtask

  task automatic load_cfg(logic [7:0] v);
    @(negedge clk_i); cfg_wr_i = 1'b1; cfg_data_i = v;
    @(negedge clk_i); cfg_wr_i = 1'b0;
  endtask

  task automatic inst_ticks(int n);
    if (n > 0) begin
      @(negedge clk_i); inst_tick_i = 1'b1;
      repeat (n) @(negedge clk_i);
      inst_tick_i = 1'b0;
    end
    settle();
  endtask

  task automatic wdt_ticks(int n);
    if (n > 0) begin
      @(negedge clk_i); wdt_tick_i = 1'b1;
      repeat (n) @(negedge clk_i);
      wdt_tick_i = 1'b0;
    end
    settle();
  endtask

  task automatic wdt_restart();
    @(negedge clk_i); wdt_clr_i = 1'b1;
    @(negedge clk_i); wdt_clr_i = 1'b0;
  endtask

  task automatic pin_to(logic v);
    @(negedge clk_i); ext_clk_i = v;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_reset();
    int base;
    chk("R1 tmr", tmr_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 timeout", to_cnt, 0);
    inst_ticks(5);
    chk("R1 R3 inst ignored on ext source", tmr_o, 0);
    pin_to(1'b1);
    chk("R1 R4 rise ignored on falling edge", tmr_o, 0);
    base = tmr_o;
    @(negedge clk_i); ext_clk_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    chk("R4 no count after two edges", tmr_o, base);
    @(negedge clk_i);
    chk("R4 count after third edge", tmr_o, base + 1);
    settle();
  endtask

  task automatic t_ext_rise();
    int base;
    load_cfg(8'h28);
    base = tmr_o;
    pin_to(1'b1);
    chk("R2 R4 rising counts", tmr_o, base + 1);
    pin_to(1'b0);
    chk("R4 falling ignored", tmr_o, base + 1);
    inst_ticks(3);
    chk("R3 inst ignored", tmr_o, base + 1);
  endtask

  task automatic t_int_div();
    int base;
    load_cfg(8'h00);
    base = tmr_o;
    pin_to(1'b1); pin_to(1'b0);
    chk("R3 pin ignored on internal source", tmr_o, base);
    inst_ticks(6);
    chk("R5 div2", tmr_o, (base + 3) & 255);
    load_cfg(8'h02); base = tmr_o;
    inst_ticks(16);
    chk("R5 div8", tmr_o, (base + 2) & 255);
    load_cfg(8'h07); base = tmr_o;
    inst_ticks(255);
    chk("R5 div256 partial", tmr_o, base);
    inst_ticks(1);
    chk("R5 div256 full", tmr_o, (base + 1) & 255);
    load_cfg(8'h08); base = tmr_o;
    inst_ticks(5);
    chk("R6 undivided", tmr_o, (base + 5) & 255);
  endtask

  task automatic t_cfg_clear();
    int base;
    load_cfg(8'h02); base = tmr_o;
    inst_ticks(7);
    chk("R8 before reload", tmr_o, base);
    load_cfg(8'h02);
    inst_ticks(7);
    chk("R8 residue discarded", tmr_o, base);
    inst_ticks(1);
    chk("R8 full period", tmr_o, (base + 1) & 255);
  endtask

  task automatic t_ovf();
    load_cfg(8'h08);
    inst_ticks((255 - tmr_o) & 255);
    chk("R9 at max", tmr_o, 255);
    chk("R9 no flag yet", ovf_o, 0);
    inst_ticks(1);
    chk("R9 wrapped", tmr_o, 0);
    chk("R9 flag set", ovf_o, 1);
    inst_ticks(3);
    chk("R9 flag held", ovf_o, 1);
    @(negedge clk_i); ovf_clr_i = 1'b1;
    @(negedge clk_i); ovf_clr_i = 1'b0;
    chk("R9 flag cleared", ovf_o, 0);
    inst_ticks((255 - tmr_o) & 255);
    @(negedge clk_i); inst_tick_i = 1'b1; ovf_clr_i = 1'b1;
    @(negedge clk_i); inst_tick_i = 1'b0; ovf_clr_i = 1'b0;
    chk("R9 wrap beats clear", ovf_o, 1);
    @(negedge clk_i); ovf_clr_i = 1'b1;
    @(negedge clk_i); ovf_clr_i = 1'b0;
  endtask

  task automatic t_wdt();
    int base;
    load_cfg(8'h00);
    base = to_cnt;
    wdt_ticks(255);
    chk("R7 undivided partial", to_cnt, base);
    wdt_ticks(1);
    chk("R7 R10 timeout once", to_cnt, base + 1);
    load_cfg(8'h09); base = to_cnt;
    wdt_ticks(511);
    chk("R7 div2 partial", to_cnt, base);
    wdt_ticks(1);
    chk("R7 div2 timeout", to_cnt, base + 1);
  endtask

  task automatic t_wdt_clr();
    int base;
    load_cfg(8'h00); base = to_cnt;
    wdt_ticks(200);
    wdt_restart();
    wdt_ticks(255);
    chk("R10 counter restarted", to_cnt, base);
    wdt_ticks(1);
    chk("R10 timeout after restart", to_cnt, base + 1);
    load_cfg(8'h09); base = to_cnt;
    wdt_ticks(1);
    wdt_restart();
    wdt_ticks(511);
    chk("R10 prescaler emptied", to_cnt, base);
    wdt_ticks(1);
    chk("R10 timeout full period", to_cnt, base + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 tmr in reset", tmr_o, 0);
    rst_ni = 1'b1;
    settle();
    t_reset();
    t_ext_rise();
    t_int_div();
    t_cfg_clear();
    t_ovf();
    t_wdt();
    t_wdt_clr();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule